// File: doc/BRIEF.md
# I2C SCL Clock Generator

This block times the SCL line of an I2C master from the module clock. Three programmable values set the timing: a prescaler that divides the module clock into a slower counting rate, a low-phase divider and a high-phase divider. Each SCL phase lasts its divider value plus a fixed extra delay, counted in prescaled ticks. The extra delay depends on the prescaler setting. A full SCL period is therefore `(prescaler+1) × ((low + d) + (high + d))` module clocks. Software should pick a prescaler that places the prescaled rate between roughly 7 and 12 MHz.

The configuration values can be written only while the controller enable is low. While the enable is low, SCL is released and every counter is held at zero. Programmed values take effect when the enable rises. The bus engine raises `run` to request clocking. The low phase is counted first. The high phase is counted only in cycles where the wired SCL line is seen high, so a slave that holds SCL low stretches the high phase. When `run` falls, the high phase in progress completes and SCL then stays released. The block gives the bus engine single-cycle strobes: one at each SCL falling edge, for changing data, and one at mid-high, for sampling data. It also exposes the prescaled tick.

All pins are plain control and status signals. No interface at this block's edge carries a data stream, so no valid/ready handshake is needed.

Top module: `scl_clock_gen`

## Requirements
- R1: After reset `scl_oe`, `fall_stb`, `mid_stb` and `presc_tick` are 0. Readback gives prescaler 0, low divider 8 and high divider 8.
- R2: While `ctrl_en` is 0, a write with `cfg_we` stores `cfg_wdata` at the selected register. Register select 0 is the prescaler, 1 is the low divider and 2 is the high divider. `cfg_rdata` returns the register selected by `cfg_addr`, and select 3 reads as zero.
- R3: A write while `ctrl_en` is 1 has no effect, and readback still returns the old value.
- R4: With prescaler 0 the extra delay is 7. The low phase (`scl_oe` high) lasts `(low+7)` module clocks.
- R5: With prescaler 1 the extra delay is 6; with prescaler 2 or more it is 5. The low phase lasts `(psc+1)*(low+d)` module clocks.
- R6: When SCL rises as soon as it is released, the high phase lasts `(psc+1)*(high+d)` module clocks, measured from the release to the next drive.
- R7: Each clock edge at which `scl_in` is sampled low after release delays the high phase by exactly one clock. The mid-high strobe moves by the same amount.
- R8: `fall_stb` is high for exactly the one cycle in which `scl_oe` first becomes 1 for each low phase.
- R9: `mid_stb` pulses for one cycle, `(psc+1)*floor((high+d)/2)` clocks after release when no stretching occurs, and only while SCL is released.
- R10: `presc_tick` pulses once every `psc+1` clocks while a phase is being counted. It pulses exactly `low+d` times per low phase and never pulses while idle.
- R11: Dropping `ctrl_en` releases SCL at the next clock edge. After that no strobe or tick appears until `ctrl_en` returns.
- R12: After `run` falls, the current high phase completes and SCL stays released. The number of low phases equals the number of mid strobes that occurred while `run` was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_en | input | 1 | Controller enable; 0 holds timing in reset and opens config writes |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Register select (0 prescaler, 1 low, 2 high) |
| cfg_wdata | input | 16 | Configuration write data |
| cfg_rdata | output | 16 | Readback of the selected register |
| run | input | 1 | Clocking request from the bus engine |
| scl_in | input | 1 | Sampled state of the wired SCL line |
| scl_oe | output | 1 | 1 pulls SCL low, 0 releases it |
| presc_tick | output | 1 | Prescaled clock enable |
| fall_stb | output | 1 | One-cycle strobe at each SCL falling edge |
| mid_stb | output | 1 | One-cycle strobe at the middle of SCL high |

## Verification
Most internal faults show up as a wrong phase length. A phase counter or prescaler that is off by one, or a wrong extra-delay choice, changes the measured low or high length within the first SCL period after `run` rises, and it changes the ticks counted per low phase. A state machine stuck in the high phase, or one that ignores `scl_in`, appears as a missing or extra falling strobe, or as a mid-high strobe displaced from the stretch-shifted time. A register that accepts writes while enabled is caught at once by readback.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } scl_phase_e;

  localparam int unsigned SEL_W = 2;
  localparam logic [SEL_W-1:0] SEL_PSC  = 2'd0;
  localparam logic [SEL_W-1:0] SEL_LOW  = 2'd1;
  localparam logic [SEL_W-1:0] SEL_HIGH = 2'd2;

  // Fixed per-phase overhead in prescaled ticks, chosen by the prescaler.
  function automatic logic [2:0] extra_delay(input logic psc_is_zero,
                                             input logic psc_is_one);
    if (psc_is_zero)     return 3'd7;
    else if (psc_is_one) return 3'd6;
    else                 return 3'd5;
  endfunction

endpackage

// File: rtl/scl_cfg_regs.sv
module scl_cfg_regs
  import scl_gen_pkg::*;
#(
  parameter int unsigned DW       = 16,
  parameter int unsigned RST_PSC  = 0,
  parameter int unsigned RST_LOW  = 8,
  parameter int unsigned RST_HIGH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_en,
  input  logic             we,
  input  logic [SEL_W-1:0] addr,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  output logic [DW-1:0]    psc,
  output logic [DW-1:0]    low_div,
  output logic [DW-1:0]    high_div
);

  logic wr_ok;
  assign wr_ok = we && !ctrl_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc      <= DW'(RST_PSC);
      low_div  <= DW'(RST_LOW);
      high_div <= DW'(RST_HIGH);
    end else if (wr_ok) begin
      case (addr)
        SEL_PSC:  psc      <= wdata;
        SEL_LOW:  low_div  <= wdata;
        SEL_HIGH: high_div <= wdata;
        default:  ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      SEL_PSC:  rdata = psc;
      SEL_LOW:  rdata = low_div;
      SEL_HIGH: rdata = high_div;
      default:  rdata = '0;
    endcase
  end

  // R3
  cfg_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_en && we) |=> ($stable(psc) && $stable(low_div) && $stable(high_div)));

endmodule

// File: rtl/scl_prescaler.sv
module scl_prescaler #(
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cnt_en,
  input  logic [DW-1:0] psc,
  output logic          tick
);

  logic [DW-1:0] cnt;

  assign tick = cnt_en && (cnt == psc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (!cnt_en) cnt <= '0;
    else if (tick)    cnt <= '0;
    else              cnt <= cnt + DW'(1);
  end

  // R10
  presc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= psc);

endmodule

// File: rtl/scl_phase_ctrl.sv
module scl_phase_ctrl
  import scl_gen_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctrl_en,
  input  logic          run,
  input  logic          scl_in,
  input  logic [DW-1:0] psc,
  input  logic [DW-1:0] low_div,
  input  logic [DW-1:0] high_div,
  input  logic          tick,
  output logic          cnt_en,
  output logic          scl_oe,
  output logic          fall_stb,
  output logic          mid_stb
);

  localparam int unsigned CW = DW + 1;

  scl_phase_e      state;
  logic [CW-1:0]   pcnt;
  logic [2:0]      dly;
  logic [CW-1:0]   low_lim;
  logic [CW-1:0]   high_lim;
  logic [CW-1:0]   half_lim;
  logic            low_done;
  logic            high_done;
  logic            at_mid;

  assign dly       = extra_delay(psc == '0, psc == DW'(1));
  assign low_lim   = {1'b0, low_div}  + CW'(dly);
  assign high_lim  = {1'b0, high_div} + CW'(dly);
  assign half_lim  = high_lim >> 1;
  assign low_done  = tick && (pcnt == low_lim - CW'(1));
  assign high_done = tick && (pcnt == high_lim - CW'(1));
  assign at_mid    = tick && (pcnt == half_lim - CW'(1));

  assign cnt_en = ctrl_en &&
                  ((state == PH_LOW) || ((state == PH_HIGH) && scl_in));
  assign scl_oe = (state == PH_LOW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= PH_IDLE;
      pcnt     <= '0;
      fall_stb <= 1'b0;
      mid_stb  <= 1'b0;
    end else if (!ctrl_en) begin
      state    <= PH_IDLE;
      pcnt     <= '0;
      fall_stb <= 1'b0;
      mid_stb  <= 1'b0;
    end else begin
      fall_stb <= 1'b0;
      mid_stb  <= 1'b0;
      case (state)
        PH_IDLE: begin
          pcnt <= '0;
          if (run) begin
            state    <= PH_LOW;
            fall_stb <= 1'b1;
          end
        end
        PH_LOW: begin
          if (low_done) begin
            state <= PH_HIGH;
            pcnt  <= '0;
          end else if (tick) begin
            pcnt <= pcnt + CW'(1);
          end
        end
        PH_HIGH: begin
          mid_stb <= at_mid;
          if (high_done) begin
            pcnt <= '0;
            if (run) begin
              state    <= PH_LOW;
              fall_stb <= 1'b1;
            end else begin
              state <= PH_IDLE;
            end
          end else if (tick) begin
            pcnt <= pcnt + CW'(1);
          end
        end
        default: begin
          state <= PH_IDLE;
          pcnt  <= '0;
        end
      endcase
    end
  end

  // R8
  fall_in_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_stb |-> scl_oe);

  // R8
  fall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_stb |=> !fall_stb);

  // R9
  mid_in_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mid_stb |-> !scl_oe);

  // R11
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_en |=> (!scl_oe && !fall_stb && !mid_stb));

  // R7
  stretch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_en && (state == PH_HIGH) && !scl_in) |=> $stable(pcnt));

endmodule

// File: rtl/scl_clock_gen.sv
module scl_clock_gen #(
  parameter int unsigned DW       = 16,
  parameter int unsigned RST_PSC  = 0,
  parameter int unsigned RST_LOW  = 8,
  parameter int unsigned RST_HIGH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctrl_en,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  output logic [DW-1:0] cfg_rdata,
  input  logic          run,
  input  logic          scl_in,
  output logic          scl_oe,
  output logic          presc_tick,
  output logic          fall_stb,
  output logic          mid_stb
);

  logic [DW-1:0] psc;
  logic [DW-1:0] low_div;
  logic [DW-1:0] high_div;
  logic          cnt_en;
  logic          tick;

  scl_cfg_regs #(
    .DW(DW), .RST_PSC(RST_PSC), .RST_LOW(RST_LOW), .RST_HIGH(RST_HIGH)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .ctrl_en(ctrl_en),
    .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata), .rdata(cfg_rdata),
    .psc(psc), .low_div(low_div), .high_div(high_div)
  );

  scl_prescaler #(.DW(DW)) u_presc (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .psc(psc), .tick(tick)
  );

  scl_phase_ctrl #(.DW(DW)) u_phase (
    .clk(clk), .rst_n(rst_n), .ctrl_en(ctrl_en), .run(run), .scl_in(scl_in),
    .psc(psc), .low_div(low_div), .high_div(high_div), .tick(tick),
    .cnt_en(cnt_en), .scl_oe(scl_oe), .fall_stb(fall_stb), .mid_stb(mid_stb)
  );

  assign presc_tick = tick;

endmodule

// File: tb/tb_scl_clock_gen.sv
module tb_scl_clock_gen;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl_en = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = 2'd0;
  logic [15:0] cfg_wdata = 16'd0;
  logic [15:0] cfg_rdata;
  logic        run = 1'b0;
  logic        scl_in;
  logic        scl_oe;
  logic        presc_tick;
  logic        fall_stb;
  logic        mid_stb;

  always #2 clk = ~clk;

  scl_clock_gen dut (
    .clk(clk), .rst_n(rst_n), .ctrl_en(ctrl_en), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .run(run), .scl_in(scl_in), .scl_oe(scl_oe), .presc_tick(presc_tick),
    .fall_stb(fall_stb), .mid_stb(mid_stb)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 0;

  // scoreboard queues of expected measurements
  int q_low[$];
  int q_high[$];
  int q_mid[$];
  int q_tick[$];
  string low_tag, high_tag, mid_tag;

  bit mon_on = 0;
  bit prev_oe = 0;
  bit have_rel = 0;
  int rise_cyc = 0, rel_cyc = 0, tc = 0;
  int rise_cnt = 0, mid_seen = 0;
  int stretch_x = 0;
  int sc = 0;

  // slave model: wired line, optionally held low after release
  assign scl_in = !scl_oe && (sc == 0);

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int pop_q(int kind);
    int v;
    v = -1;
    case (kind)
      0: if (q_low.size()  > 0) v = q_low.pop_front();
      1: if (q_high.size() > 0) v = q_high.pop_front();
      2: if (q_mid.size()  > 0) v = q_mid.pop_front();
      default: if (q_tick.size() > 0) v = q_tick.pop_front();
    endcase
    return v;
  endfunction

  always @(negedge clk) begin
    if (scl_oe) sc = (stretch_x == 0) ? 0 : stretch_x + 1;
    else if (sc > 0) sc = sc - 1;
  end

  // monitor
  always @(negedge clk) begin
    if (mon_on) begin
      if (scl_oe && !prev_oe) begin
        rise_cnt++;
        chk("R8 falling strobe", int'(fall_stb), 1);
        if (have_rel) chk(high_tag, cyc - rel_cyc, pop_q(1));
        rise_cyc = cyc;
        tc = presc_tick ? 1 : 0;
      end else if (scl_oe && presc_tick) begin
        tc++;
      end
      if (!scl_oe && prev_oe) begin
        chk(low_tag, cyc - rise_cyc, pop_q(0));
        chk("R10 ticks per low phase", tc, pop_q(3));
        rel_cyc = cyc;
        have_rel = 1;
      end
      if (mid_stb) begin
        chk(mid_tag, cyc - rel_cyc, pop_q(2));
        mid_seen++;
      end
    end
    prev_oe = scl_oe;
  end

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd_chk(string tag, logic [1:0] a, int exp);
    @(negedge clk);
    cfg_addr = a;
    #1;
    chk(tag, int'(cfg_rdata), exp);
  endtask

  task automatic run_case(int p, int lo, int hi, int n, int x,
                          string ltag, string htag, string mtag);
    int d;
    @(negedge clk);
    ctrl_en = 1'b0; run = 1'b0;
    wr(2'd0, 16'(p)); wr(2'd1, 16'(lo)); wr(2'd2, 16'(hi));
    rd_chk("R2 prescaler readback", 2'd0, p);
    rd_chk("R2 low readback", 2'd1, lo);
    rd_chk("R2 high readback", 2'd2, hi);
    d = (p == 0) ? 7 : ((p == 1) ? 6 : 5);
    for (int i = 0; i < n; i++) begin
      q_low.push_back((p + 1) * (lo + d));
      q_tick.push_back(lo + d);
      q_mid.push_back((p + 1) * ((hi + d) / 2) + x);
      if (i < n - 1) q_high.push_back((p + 1) * (hi + d) + x);
    end
    low_tag = ltag; high_tag = htag; mid_tag = mtag;
    stretch_x = x;
    have_rel = 0; rise_cnt = 0; mid_seen = 0;
    mon_on = 1;
    @(negedge clk);
    ctrl_en = 1'b1; run = 1'b1;
    wait (mid_seen == n);
    run = 1'b0;
    repeat ((p + 1) * (hi + d) + x + 30) @(negedge clk);
    chk("R12 low phases after run drop", rise_cnt, n);
    chk("R12 SCL released at end", int'(scl_oe), 0);
    chk("R12 scoreboard drained",
        q_low.size() + q_high.size() + q_mid.size() + q_tick.size(), 0);
    mon_on = 0;
    stretch_x = 0;
    ctrl_en = 1'b0;
  endtask

  initial begin
    int act;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 scl_oe", int'(scl_oe), 0);
    chk("R1 fall_stb", int'(fall_stb), 0);
    chk("R1 mid_stb", int'(mid_stb), 0);
    chk("R1 presc_tick", int'(presc_tick), 0);
    rst_n = 1'b1;
    rd_chk("R1 reset prescaler", 2'd0, 0);
    rd_chk("R1 reset low", 2'd1, 8);
    rd_chk("R1 reset high", 2'd2, 8);
    rd_chk("R2 select 3 reads zero", 2'd3, 0);

    // R10 / R12: enabled but idle gives no activity
    @(negedge clk); ctrl_en = 1'b1;
    act = 0;
    repeat (20) begin
      @(negedge clk);
      act += int'(presc_tick) + int'(scl_oe) + int'(fall_stb) + int'(mid_stb);
    end
    chk("R10 idle has no tick or SCL drive", act, 0);

    // R3 writes while enabled are dropped
    wr(2'd0, 16'd5);
    wr(2'd2, 16'd77);
    rd_chk("R3 prescaler unchanged", 2'd0, 0);
    rd_chk("R3 high unchanged", 2'd2, 8);
    @(negedge clk); ctrl_en = 1'b0;

    run_case(0, 3, 4, 3, 0, "R4 low phase psc0", "R6 high phase psc0", "R9 mid strobe psc0");
    run_case(1, 2, 5, 2, 0, "R5 low phase psc1", "R6 high phase psc1", "R9 mid strobe psc1");
    run_case(2, 1, 1, 2, 0, "R5 low phase psc2", "R6 high phase psc2", "R9 mid strobe psc2");
    run_case(3, 0, 10, 2, 0, "R5 low phase psc3", "R6 high phase psc3", "R9 mid strobe psc3");
    run_case(0, 3, 4, 3, 13, "R4 low phase stretch", "R7 stretched high", "R7 stretched mid");

    // R11 drop enable mid-transfer
    @(negedge clk);
    ctrl_en = 1'b1; run = 1'b1;
    wait (scl_oe == 1'b1);
    repeat (4) @(negedge clk);
    ctrl_en = 1'b0;
    @(negedge clk);
    chk("R11 SCL released after enable drop", int'(scl_oe), 0);
    act = 0;
    repeat (20) begin
      @(negedge clk);
      act += int'(presc_tick) + int'(scl_oe) + int'(fall_stb) + int'(mid_stb);
    end
    chk("R11 quiet while disabled", act, 0);
    run = 1'b0;

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule